// File: doc/BRIEF.md
# Destination Pending Filter for Reorder-Buffer Lookups

This block keeps one status bit per architectural register that says whether any instruction still in flight in the reorder buffer will write that register. Alongside the bitmap it holds a small content-addressable table with one entry per reorder-buffer slot, and each entry records the destination register of the instruction in that slot. When an operand is looked up, the block first reads the register's status bit. Only when that bit is set does it enable the table search, which returns the slot of the youngest in-flight writer. A clear bit means the operand is read from the register file, and the search stays idle, which saves the power of comparing every entry.

Up to two instructions are allocated per cycle, and the block hands out their slot tags in circular order. Up to two of the oldest instructions retire per cycle. Retiring an instruction clears its register's bit only when no other in-flight instruction still targets that register. A flush empties the whole structure in one cycle. Lookups are combinational and read the state held at the start of the cycle.

Top module: `dest_pending_filter`

## Requirements
- R1: After reset, no register is pending, and every lookup reports pending 0, search 0 and tag 0.
- R2: An allocation whose destination is not register 0 makes that register pending, and lookups see this from the cycle after the allocating clock edge.
- R3: Slot tags are handed out in circular order starting at 0 after reset or flush. When both allocation ports are valid, port 0 takes the current tail and port 1 takes the next slot. When only port 1 is valid, it takes the current tail.
- R4: A lookup of a pending register reports pending 1 and the tag of the youngest in-flight instruction that targets it, where age follows allocation order.
- R5: When both ports allocate the same register in one cycle, later lookups return the tag of port 1.
- R6: Retire port 0 retires the oldest in-flight instruction, and port 1 retires the one after it; port 1 is only used together with port 0. A register stays pending after a retire while any remaining in-flight instruction targets it, and lookups then return the youngest remaining writer. Otherwise the register becomes not pending.
- R7: Flush clears every pending bit and every table entry at the next edge, restarts tag allocation at 0, and overrides any allocation or retire in the same cycle.
- R8: Register 0 is never pending. An allocation to register 0 still consumes a slot tag.
- R9: The search output of a read port is 1 exactly when the queried register's pending bit is set. When it is 0, pending and tag read 0.
- R10: A lookup in the same cycle as an allocation or retire reports the state held before that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard all in-flight state |
| allocValid | input | 2 | Allocation request per port (bit 0 = port 0) |
| allocDest0 | input | 7 | Destination register, allocation port 0 |
| allocDest1 | input | 7 | Destination register, allocation port 1 |
| allocTag0 | output | 4 | Slot tag given to allocation port 0 |
| allocTag1 | output | 4 | Slot tag given to allocation port 1 |
| retireValid | input | 2 | Retire oldest (bit 0) and next-oldest (bit 1) |
| srcReg | input | 4x7 | Register queried by each read port |
| lookupPending | output | 4 | Queried register has an in-flight writer |
| lookupSearch | output | 4 | Table search enabled for this read port |
| lookupTag | output | 4x4 | Slot of the youngest in-flight writer |

## Verification
The assertions assume that the environment never retires more instructions than are in flight, never allocates beyond the slot count once the same cycle's retires are taken into account, and only raises retire port 1 together with port 0. The checker tracks occupancy from the port traffic alone to police these assumptions. The random stimulus reads its own reference occupancy before choosing each cycle's retires and allocations, so it keeps within these limits while still driving the table full and empty. Destinations and queried registers are drawn from a narrow range so that several in-flight writers of one register are common.

// File: rtl/dpb_pkg.sv
package dpb_pkg;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic       flush;
    logic [1:0] allocWe;
    logic [1:0] retireEn;
  } dpb_strobe_t;

endpackage

// File: rtl/dpb_ctrl.sv
module dpb_ctrl
  import dpb_pkg::*;
#(
  parameter int ROB_DEPTH = 16,
  localparam int TAG_W = $clog2(ROB_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [1:0]       allocValid,
  input  logic [1:0]       retireValid,
  output dpb_strobe_t      strobe,
  output logic [TAG_W-1:0] allocSlot0,
  output logic [TAG_W-1:0] allocSlot1,
  output logic [TAG_W-1:0] retireSlot0,
  output logic [TAG_W-1:0] retireSlot1,
  output logic [TAG_W-1:0] headPtr
);

  logic [TAG_W-1:0] tailPtr;

  // Port 1 lands after port 0 only when port 0 also allocates
  assign allocSlot0  = tailPtr;
  assign allocSlot1  = tailPtr + TAG_W'(allocValid[0]);
  assign retireSlot0 = headPtr;
  assign retireSlot1 = headPtr + TAG_W'(retireValid[0]);

  always_comb begin
    strobe.flush    = flush;
    strobe.allocWe  = flush ? 2'b00 : allocValid;
    strobe.retireEn = flush ? 2'b00 : retireValid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (flush) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      headPtr <= headPtr + TAG_W'(retireValid[0]) + TAG_W'(retireValid[1]);
      tailPtr <= tailPtr + TAG_W'(allocValid[0]) + TAG_W'(allocValid[1]);
    end
  end

endmodule

// File: rtl/dpb_datapath.sv
module dpb_datapath
  import dpb_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int ROB_DEPTH = 16,
  parameter int NUM_READ  = 4,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(ROB_DEPTH)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  dpb_strobe_t                     strobe,
  input  logic [TAG_W-1:0]                allocSlot0,
  input  logic [TAG_W-1:0]                allocSlot1,
  input  logic [REG_W-1:0]                allocDest0,
  input  logic [REG_W-1:0]                allocDest1,
  input  logic [TAG_W-1:0]                retireSlot0,
  input  logic [TAG_W-1:0]                retireSlot1,
  input  logic [TAG_W-1:0]                headPtr,
  input  logic [NUM_READ-1:0][REG_W-1:0]  srcReg,
  output logic [NUM_READ-1:0]             lookupPending,
  output logic [NUM_READ-1:0]             lookupSearch,
  output logic [NUM_READ-1:0][TAG_W-1:0]  lookupTag,
  output logic [NUM_REGS-1:0]             pendMap
);

  logic [ROB_DEPTH-1:0] entryValid;
  logic [REG_W-1:0]     entryDest [ROB_DEPTH];

  logic [1:0][TAG_W-1:0] retSlot;
  logic [1:0][REG_W-1:0] retDest;
  logic [1:0]            otherWriter;
  logic [1:0]            clearOk;
  logic [NUM_REGS-1:0]   mapNext;

  assign retSlot[0] = retireSlot0;
  assign retSlot[1] = retireSlot1;

  // A retiring register is released only if no surviving entry writes it
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      retDest[p]     = entryDest[retSlot[p]];
      otherWriter[p] = 1'b0;
      for (int s = 0; s < ROB_DEPTH; s++) begin
        if (entryValid[s] && entryDest[s] == retDest[p]
            && !(strobe.retireEn[0] && retireSlot0 == TAG_W'(s))
            && !(strobe.retireEn[1] && retireSlot1 == TAG_W'(s)))
          otherWriter[p] = 1'b1;
      end
      clearOk[p] = strobe.retireEn[p] && entryValid[retSlot[p]] && !otherWriter[p];
    end
  end

  // Clears first, then sets, so a same-cycle allocation keeps the bit
  always_comb begin
    mapNext = pendMap;
    for (int p = 0; p < 2; p++)
      if (clearOk[p]) mapNext[retDest[p]] = 1'b0;
    if (strobe.allocWe[0] && allocDest0 != '0) mapNext[allocDest0] = 1'b1;
    if (strobe.allocWe[1] && allocDest1 != '0) mapNext[allocDest1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pendMap <= '0;
    else if (strobe.flush) pendMap <= '0;
    else                   pendMap <= mapNext;
  end

  // Destination table: retire invalidates, allocation (later) overwrites
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entryValid <= '0;
      for (int s = 0; s < ROB_DEPTH; s++) entryDest[s] <= '0;
    end else if (strobe.flush) begin
      entryValid <= '0;
    end else begin
      for (int s = 0; s < ROB_DEPTH; s++) begin
        if ((strobe.retireEn[0] && retireSlot0 == TAG_W'(s)) ||
            (strobe.retireEn[1] && retireSlot1 == TAG_W'(s)))
          entryValid[s] <= 1'b0;
        if (strobe.allocWe[0] && allocSlot0 == TAG_W'(s)) begin
          entryValid[s] <= (allocDest0 != '0);
          entryDest[s]  <= allocDest0;
        end
        if (strobe.allocWe[1] && allocSlot1 == TAG_W'(s)) begin
          entryValid[s] <= (allocDest1 != '0);
          entryDest[s]  <= allocDest1;
        end
      end
    end
  end

  // Read ports: the bitmap bit gates the search; scan oldest to youngest
  for (genvar r = 0; r < NUM_READ; r++) begin : g_read
    logic             searchOn;
    logic             hit;
    logic [TAG_W-1:0] idx;
    logic [TAG_W-1:0] tag;

    always_comb begin
      searchOn = pendMap[srcReg[r]];
      hit      = 1'b0;
      tag      = '0;
      idx      = '0;
      for (int k = 0; k < ROB_DEPTH; k++) begin
        idx = headPtr + TAG_W'(k);
        if (searchOn && entryValid[idx] && entryDest[idx] == srcReg[r]) begin
          hit = 1'b1;
          tag = idx;
        end
      end
    end

    assign lookupSearch[r]  = searchOn;
    assign lookupPending[r] = hit;
    assign lookupTag[r]     = tag;
  end

endmodule

// File: rtl/dest_pending_filter.sv
module dest_pending_filter
  import dpb_pkg::*;
#(
  parameter int NUM_REGS  = 128,
  parameter int ROB_DEPTH = 16,
  parameter int NUM_READ  = 4,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(ROB_DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           flush,
  input  logic [1:0]                     allocValid,
  input  logic [REG_W-1:0]               allocDest0,
  input  logic [REG_W-1:0]               allocDest1,
  output logic [TAG_W-1:0]               allocTag0,
  output logic [TAG_W-1:0]               allocTag1,
  input  logic [1:0]                     retireValid,
  input  logic [NUM_READ-1:0][REG_W-1:0] srcReg,
  output logic [NUM_READ-1:0]            lookupPending,
  output logic [NUM_READ-1:0]            lookupSearch,
  output logic [NUM_READ-1:0][TAG_W-1:0] lookupTag
);

  dpb_strobe_t         strobe;
  logic [TAG_W-1:0]    retireSlot0, retireSlot1, headPtr;
  logic [NUM_REGS-1:0] pendMap;

  dpb_ctrl #(.ROB_DEPTH(ROB_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .allocValid(allocValid), .retireValid(retireValid),
    .strobe(strobe),
    .allocSlot0(allocTag0), .allocSlot1(allocTag1),
    .retireSlot0(retireSlot0), .retireSlot1(retireSlot1),
    .headPtr(headPtr)
  );

  dpb_datapath #(.NUM_REGS(NUM_REGS), .ROB_DEPTH(ROB_DEPTH), .NUM_READ(NUM_READ)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .allocSlot0(allocTag0), .allocSlot1(allocTag1),
    .allocDest0(allocDest0), .allocDest1(allocDest1),
    .retireSlot0(retireSlot0), .retireSlot1(retireSlot1),
    .headPtr(headPtr), .srcReg(srcReg),
    .lookupPending(lookupPending), .lookupSearch(lookupSearch),
    .lookupTag(lookupTag), .pendMap(pendMap)
  );

endmodule

// File: rtl/dpb_checker.sv
module dpb_checker #(
  parameter int NUM_REGS  = 128,
  parameter int ROB_DEPTH = 16,
  parameter int NUM_READ  = 4,
  localparam int REG_W = $clog2(NUM_REGS),
  localparam int TAG_W = $clog2(ROB_DEPTH),
  localparam int OCC_W = TAG_W + 1
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           flush,
  input logic [1:0]                     allocValid,
  input logic [REG_W-1:0]               allocDest0,
  input logic [TAG_W-1:0]               allocTag0,
  input logic [TAG_W-1:0]               allocTag1,
  input logic [1:0]                     retireValid,
  input logic [NUM_READ-1:0][REG_W-1:0] srcReg,
  input logic [NUM_READ-1:0]            lookupPending,
  input logic [NUM_REGS-1:0]            pendMap
);

  // Occupancy rebuilt from port traffic only
  logic [OCC_W-1:0] occ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     occ <= '0;
    else if (flush) occ <= '0;
    else occ <= occ + OCC_W'(allocValid[0]) + OCC_W'(allocValid[1])
                    - OCC_W'(retireValid[0]) - OCC_W'(retireValid[1]);
  end

  assert_occupancy_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(ROB_DEPTH));

  assert_retire_pairing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    retireValid[1] |-> retireValid[0]);

  assert_tag_sequence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (allocValid == 2'b11) |-> (allocTag1 == allocTag0 + TAG_W'(1)));

  assert_alloc_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (allocValid[0] && !flush && allocDest0 != '0) |=> pendMap[$past(allocDest0)]);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (pendMap == '0));

  assert_reg_zero_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !pendMap[0]);

  assert_bitmap_agrees_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lookupPending[0] == pendMap[srcReg[0]]);

endmodule

bind dest_pending_filter dpb_checker #(
  .NUM_REGS(NUM_REGS), .ROB_DEPTH(ROB_DEPTH), .NUM_READ(NUM_READ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .allocValid(allocValid), .allocDest0(allocDest0),
  .allocTag0(allocTag0), .allocTag1(allocTag1),
  .retireValid(retireValid), .srcReg(srcReg),
  .lookupPending(lookupPending), .pendMap(pendMap)
);

// File: tb/tb_dest_pending_filter.sv
`timescale 1ns/1ps
module tb_dest_pending_filter;
  localparam int NR = 128;
  localparam int D  = 16;
  localparam int NP = 4;
  localparam int RW = $clog2(NR);
  localparam int TW = $clog2(D);

  logic clk = 0, rst_n = 0, flush = 0;
  logic [1:0] allocValid = 0, retireValid = 0;
  logic [RW-1:0] allocDest0 = 0, allocDest1 = 0;
  logic [TW-1:0] allocTag0, allocTag1;
  logic [NP-1:0][RW-1:0] srcReg = '0;
  logic [NP-1:0] lookupPending, lookupSearch;
  logic [NP-1:0][TW-1:0] lookupTag;

  always #2.5 clk = ~clk;

  dest_pending_filter dut (.*);

  int compared = 0, mismatched = 0;
  bit finished = 0;
  int mHead = 0, mTail = 0, mCount = 0;
  int mDest [D];

  function automatic void modelLookup(input int r, output bit hit, output int tag);
    hit = 0; tag = 0;
    if (r == 0) return;
    for (int k = 0; k < mCount; k++) begin
      int idx = (mHead + k) % D;
      if (mDest[idx] == r) begin hit = 1; tag = idx; end
    end
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit a0v, input int a0d, input bit a1v, input int a1d,
                      input bit r0, input bit r1, input bit fl,
                      input int s0, input int s1, input int s2, input int s3,
                      input string req);
    int srcs [NP];
    bit hit; int tag;
    srcs = '{s0, s1, s2, s3};
    allocValid = {a1v, a0v}; allocDest0 = RW'(a0d); allocDest1 = RW'(a1d);
    retireValid = {r1, r0}; flush = fl;
    for (int p = 0; p < NP; p++) srcReg[p] = RW'(srcs[p]);
    #1;
    for (int p = 0; p < NP; p++) begin
      modelLookup(srcs[p], hit, tag);
      chk(req, $sformatf("port%0d pending", p), lookupPending[p], hit);
      chk(req, $sformatf("port%0d tag", p), lookupTag[p], tag);
      chk("R9", $sformatf("port%0d search", p), lookupSearch[p], hit);
    end
    if (a0v) chk("R3", "allocTag0", allocTag0, mTail);
    if (a1v) chk("R3", "allocTag1", allocTag1, (mTail + a0v) % D);
    @(posedge clk);
    if (fl) begin
      mHead = 0; mTail = 0; mCount = 0;
    end else begin
      if (r0) begin mHead = (mHead + 1) % D; mCount--; end
      if (r1) begin mHead = (mHead + 1) % D; mCount--; end
      if (a0v) begin mDest[mTail] = a0d; mTail = (mTail + 1) % D; mCount++; end
      if (a1v) begin mDest[mTail] = a1d; mTail = (mTail + 1) % D; mCount++; end
    end
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: empty after reset
    step(0,0, 0,0, 0,0,0, 1,2,3,0, "R1");
    // R10: same-cycle lookup sees old state; R5 set up (both to reg 5)
    step(1,5, 1,5, 0,0,0, 5,5,0,9, "R10");
    // R5: port 1 is the youngest writer
    step(0,0, 0,0, 0,0,0, 5,1,2,0, "R5");
    // R8: register 0 consumes a tag; R2: reg 9 becomes pending
    step(1,0, 1,9, 0,0,0, 5,9,0,0, "R8");
    step(0,0, 0,0, 0,0,0, 9,0,5,3, "R2");
    // R6: retire slot 0 (reg 5) while slot 1 still writes reg 5
    step(0,0, 0,0, 1,0,0, 5,9,0,0, "R6");
    step(0,0, 0,0, 0,0,0, 5,9,0,0, "R6");
    // R6: retire slots 1 and 2; reg 5 released
    step(0,0, 0,0, 1,1,0, 5,9,0,0, "R6");
    step(0,0, 0,0, 0,0,0, 5,9,0,0, "R6");
    // R7: flush overrides same-cycle allocation and retire
    step(1,7, 0,0, 1,0,1, 9,7,0,0, "R7");
    step(0,0, 0,0, 0,0,0, 9,7,0,0, "R7");
    // R3: lone port-1 allocation takes the tail, restarted at 0
    step(0,0, 1,4, 0,0,0, 4,0,0,0, "R3");
    step(1,4, 1,6, 0,0,0, 4,6,0,0, "R4");
    step(0,0, 0,0, 0,0,0, 4,6,0,0, "R4");

    for (int i = 0; i < 3000; i++) begin
      bit fl, r0, r1, a0v, a1v;
      int room;
      fl  = ($urandom % 50) == 0;
      r0  = (mCount > 0) && ($urandom % 3 == 0);
      r1  = r0 && (mCount > 1) && ($urandom % 2 == 0);
      room = D - mCount + int'(r0) + int'(r1);
      a0v = (room > 0) && ($urandom % 2 == 0);
      a1v = (room > int'(a0v)) && ($urandom % 2 == 0);
      step(a0v, $urandom % 8, a1v, ($urandom % 4 == 0) ? $urandom % NR : $urandom % 8,
           r0, r1, fl,
           $urandom % 8, $urandom % 8, $urandom % 8, $urandom % NR, "R4");
    end
    finish_run();
  end
endmodule